// File: doc/BRIEF.md
# Management-Mode Cache Flush Sequencer

This block sits in the system control logic next to a CPU that has a system-management mode. It watches two active-low CPU signals: the management interrupt request and the acknowledge that says the CPU is running its management handler. From them it keeps the caches coherent around the handler. It issues flush pulses to the CPU's internal cache and a second-level cache at the right moments. It also decides whether lines may be cached while the handler runs, and whether a write-back system is forced into write-through behaviour for that time.

Three static configuration inputs choose the policy. The first is the system cache mode, write-through or write-back. The second says whether caching is allowed during management mode. The third says whether the management memory overlays normal main memory at the same addresses. A separate management memory region never aliases main memory, so it needs no flush. An overlaid region must be flushed because cached main-memory lines would be wrong inside the handler, and cached handler lines would be wrong after it.

Both request inputs pass through a two-flop synchronizer before edge detection. The block therefore reacts to input edges with a fixed latency, and flush pulses are one clock wide by default.

Top module: `smm_flush_seq`

## Requirements
- R1: While reset is held and after it is released with idle inputs, flush_n is 1, l2_flush is 0, ken_n is 0 and wbwt equals cfg_wb.
- R2: An input edge on smi_n or smiact_n first shows at the outputs after the third rising clock edge following the change. After two edges the outputs are still unchanged.
- R3: With cfg_overlay=1 and cfg_wb=0 (write-through), a falling edge of smiact_n produces one flush pulse.
- R4: With cfg_overlay=1, cfg_wb=0 and cfg_smm_cache=1 (caching allowed), a rising edge of smiact_n produces a second flush pulse, and ken_n stays 0 throughout.
- R5: With cfg_smm_cache=0, ken_n is 1 (caching refused) from the falling edge of smi_n until the rising edge of smiact_n. In write-through mode the exit flush is then skipped.
- R6: With cfg_overlay=1 and cfg_wb=1 (write-back), the flush pulse comes on the falling edge of smi_n, none comes on either smiact_n edge, and ken_n is 1 from that pulse until smiact_n rises.
- R7: With cfg_wb=1, wbwt is 0 (write-through forced) from the falling edge of smi_n until the rising edge of smiact_n, and 1 otherwise. With cfg_wb=0, wbwt is always 0.
- R8: With cfg_overlay=0, no flush pulse is ever issued.
- R9: flush_n (active low) and l2_flush (active high) assert in the same cycles, for FLUSH_LEN cycles per event (default 1).
- R10: A rising edge of smi_n has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smi_n | input | 1 | Management interrupt request from the system, active low, asynchronous |
| smiact_n | input | 1 | Management-mode acknowledge from the CPU, active low, asynchronous |
| cfg_wb | input | 1 | 1 = write-back system, 0 = write-through system |
| cfg_smm_cache | input | 1 | 1 = caching allowed during management mode |
| cfg_overlay | input | 1 | 1 = management memory overlays main memory |
| flush_n | output | 1 | Active-low flush to the CPU internal cache |
| l2_flush | output | 1 | Active-high flush request to the second-level cache |
| ken_n | output | 1 | Active-low cache enable to the CPU; 1 refuses caching |
| wbwt | output | 1 | 1 permits write-back lines, 0 forces write-through |

## Verification
The in-line properties check on every cycle that the two flush outputs move together and that a non-overlaid setting never starts a pulse. They also check that any flush issued while caching is refused finds ken_n already high, that a permitted exit flush follows an acknowledge release, and that wbwt only returns high after an acknowledge release. Only the bench's scenarios can show the exact three-edge latency, which pulses appear for each of the eight configurations, the absence of extra pulses over a whole episode, and that releasing the request line leaves every output alone.

// File: rtl/smmf_pkg.sv
package smmf_pkg;

  // index of each monitored CPU line in the synchronizer vector
  localparam int unsigned IDX_REQ = 0;
  localparam int unsigned IDX_ACK = 1;
  localparam int unsigned NUM_LINES = 2;

  // edges that the policy acts upon
  typedef struct packed {
    logic req_fall;
    logic ack_fall;
    logic ack_rise;
  } smmf_edges_t;

  // static policy selection
  typedef struct packed {
    logic wb;
    logic smm_cache;
    logic overlay;
  } smmf_cfg_t;

endpackage

// File: rtl/smmf_rst_bridge.sv
module smmf_rst_bridge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/smmf_sync.sv
module smmf_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {(STAGES*WIDTH){RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/smmf_edge.sv
module smmf_edge
  import smmf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lvl,
  output smmf_edges_t          edges
);

  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] prev_d;

  always_comb begin
    prev_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
    end else begin
      prev_q <= prev_d;
    end
  end

  // request rising edge is deliberately not decoded: it carries no action
  always_comb begin
    edges.req_fall = prev_q[IDX_REQ] & ~lvl[IDX_REQ];
    edges.ack_fall = prev_q[IDX_ACK] & ~lvl[IDX_ACK];
    edges.ack_rise = ~prev_q[IDX_ACK] & lvl[IDX_ACK];
  end

endmodule

// File: rtl/smmf_policy.sv
module smmf_policy
  import smmf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  smmf_cfg_t   cfg,
  input  smmf_edges_t edges,
  output logic        flush_go,
  output logic        block_q,
  output logic        force_wt_q
);

  logic flush_entry;
  logic flush_exit;
  logic block_set;
  logic block_d;
  logic force_d;
  logic block_en;
  logic force_en;

  // flush event selection
  always_comb begin
    flush_entry = cfg.overlay & (cfg.wb ? edges.req_fall : edges.ack_fall);
    flush_exit  = cfg.overlay & ~cfg.wb & cfg.smm_cache & edges.ack_rise;
    flush_go    = flush_entry | flush_exit;
  end

  // cache-refusal window: set on request, cleared on acknowledge release
  always_comb begin
    block_set = edges.req_fall & ((cfg.wb & cfg.overlay) | ~cfg.smm_cache);
    block_en  = block_set | edges.ack_rise;
    block_d   = block_set;
  end

  // write-through forcing window for write-back systems
  always_comb begin
    force_en = edges.req_fall | edges.ack_rise;
    force_d  = edges.req_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      block_q <= 1'b0;
    end else if (block_en) begin
      block_q <= block_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_wt_q <= 1'b0;
    end else if (force_en) begin
      force_wt_q <= force_d;
    end
  end

  // R5: refusal ends only when the acknowledge is released
  p_block_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (block_q && !edges.ack_rise) |=> block_q);

endmodule

// File: rtl/smmf_pulse.sv
module smmf_pulse #(
  parameter int unsigned LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic pulse_n,
  output logic pulse
);

  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(LEN);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          hi_q;
  logic          hi_d;

  always_comb begin
    cnt_en = go | (cnt_q != '0);
    cnt_d  = go ? LEN_C : (cnt_q - ONE_C);
    hi_d   = go | (cnt_q > ONE_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
    end
  end

  assign pulse_n = (cnt_q == '0);
  assign pulse   = hi_q;

  // R9: both flush outputs assert and release together
  p_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_n == !pulse));

endmodule

// File: rtl/smm_flush_seq.sv
module smm_flush_seq
  import smmf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FLUSH_LEN   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smi_n,
  input  logic smiact_n,
  input  logic cfg_wb,
  input  logic cfg_smm_cache,
  input  logic cfg_overlay,
  output logic flush_n,
  output logic l2_flush,
  output logic ken_n,
  output logic wbwt
);

  logic                 rst_n_s;
  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] sync_lines;
  smmf_edges_t          edges;
  smmf_cfg_t            cfg;
  logic                 flush_go;
  logic                 block_q;
  logic                 force_wt_q;

  smmf_rst_bridge #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    raw_lines          = '1;
    raw_lines[IDX_REQ] = smi_n;
    raw_lines[IDX_ACK] = smiact_n;
    cfg.wb             = cfg_wb;
    cfg.smm_cache      = cfg_smm_cache;
    cfg.overlay        = cfg_overlay;
  end

  smmf_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   (raw_lines),
    .dout  (sync_lines)
  );

  smmf_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n_s),
    .lvl   (sync_lines),
    .edges (edges)
  );

  smmf_policy u_pol (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cfg        (cfg),
    .edges      (edges),
    .flush_go   (flush_go),
    .block_q    (block_q),
    .force_wt_q (force_wt_q)
  );

  smmf_pulse #(.LEN(FLUSH_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .go      (flush_go),
    .pulse_n (flush_n),
    .pulse   (l2_flush)
  );

  assign ken_n = block_q;
  assign wbwt  = cfg_wb & ~force_wt_q;

  // R8: a separate management region never starts a flush
  p_no_flush_sep_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cfg_overlay |=> !$fell(flush_n));

  // R5: any flush started while caching is refused finds ken_n already high
  p_ken_at_flush_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($fell(flush_n) && $past(cfg_smm_cache == 1'b0) && $stable(cfg_smm_cache)) |-> ken_n);

  // R4: a permitted exit flush follows the acknowledge release
  p_exit_flush_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (edges.ack_rise && cfg_overlay && !cfg_wb && cfg_smm_cache) |=> !flush_n);

  // R7: write-back permission returns only after the acknowledge release
  p_wbwt_return_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(wbwt) && $stable(cfg_wb)) |-> $past(edges.ack_rise));

endmodule

// File: tb/sim_smm_flush_seq.sv
`timescale 1ns/1ps
module sim_smm_flush_seq;

  logic clk = 1'b0;
  logic rst_n;
  logic smi_n, smiact_n, cfg_wb, cfg_smm_cache, cfg_overlay;
  logic flush_n, l2_flush, ken_n, wbwt;

  int checks = 0;
  int failures = 0;
  int pulse_cycles = 0;
  int pair_errs = 0;

  always #2.5 clk = ~clk;

  smm_flush_seq u0 (
    .clk(clk), .rst_n(rst_n), .smi_n(smi_n), .smiact_n(smiact_n),
    .cfg_wb(cfg_wb), .cfg_smm_cache(cfg_smm_cache), .cfg_overlay(cfg_overlay),
    .flush_n(flush_n), .l2_flush(l2_flush), .ken_n(ken_n), .wbwt(wbwt)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (!flush_n) pulse_cycles++;
      if (l2_flush !== !flush_n) pair_errs++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (wb=%0d cache=%0d ov=%0d)",
               req, what, act, exp, cfg_wb, cfg_smm_cache, cfg_overlay);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic episode(input logic wb, input logic cache, input logic ov);
    int exp_blk, exp_entry_req, exp_entry_ack, exp_exit, base;
    cfg_wb = wb; cfg_smm_cache = cache; cfg_overlay = ov;
    exp_blk       = ((wb && ov) || !cache) ? 1 : 0;
    exp_entry_req = (ov && wb) ? 1 : 0;
    exp_entry_ack = (ov && !wb) ? 1 : 0;
    exp_exit      = (ov && !wb && cache) ? 1 : 0;
    tick(3);
    base = pulse_cycles;
    chk("R7", "wbwt idle", int'(wbwt), int'(wb));
    // request asserted
    smi_n = 1'b0;
    tick(2);
    chk("R2", "flush_n before latency", int'(flush_n), 1);
    chk("R2", "ken_n before latency", int'(ken_n), 0);
    tick(1);
    chk("R6", "flush_n at request", int'(flush_n), exp_entry_req ? 0 : 1);
    chk("R9", "l2_flush at request", int'(l2_flush), exp_entry_req);
    chk("R5", "ken_n at request", int'(ken_n), exp_blk);
    chk("R7", "wbwt during mode", int'(wbwt), 0);
    tick(1);
    chk("R9", "flush_n released", int'(flush_n), 1);
    tick(3);
    // acknowledge asserted
    smiact_n = 1'b0;
    tick(3);
    chk("R3", "flush_n at ack fall", int'(flush_n), exp_entry_ack ? 0 : 1);
    chk("R9", "l2_flush at ack fall", int'(l2_flush), exp_entry_ack);
    tick(1);
    chk("R9", "flush_n released", int'(flush_n), 1);
    chk("R5", "ken_n inside mode", int'(ken_n), exp_blk);
    tick(2);
    // request released: no effect
    smi_n = 1'b1;
    tick(6);
    chk("R10", "pulses after request release", pulse_cycles - base, exp_entry_req + exp_entry_ack);
    chk("R10", "ken_n after request release", int'(ken_n), exp_blk);
    chk("R10", "wbwt after request release", int'(wbwt), 0);
    // acknowledge released
    smiact_n = 1'b1;
    tick(2);
    chk("R2", "ken_n before exit latency", int'(ken_n), exp_blk);
    tick(1);
    chk("R4", "flush_n at ack rise", int'(flush_n), exp_exit ? 0 : 1);
    chk("R4", "l2_flush at ack rise", int'(l2_flush), exp_exit);
    chk("R6", "ken_n after exit", int'(ken_n), 0);
    chk("R7", "wbwt after exit", int'(wbwt), int'(wb));
    tick(1);
    chk("R9", "flush_n released", int'(flush_n), 1);
    tick(4);
    chk("R8", "total pulse cycles", pulse_cycles - base,
        exp_entry_req + exp_entry_ack + exp_exit);
  endtask

  initial begin
    rst_n = 1'b0;
    smi_n = 1'b1; smiact_n = 1'b1;
    cfg_wb = 1'b1; cfg_smm_cache = 1'b1; cfg_overlay = 1'b1;
    tick(3);
    chk("R1", "flush_n in reset", int'(flush_n), 1);
    chk("R1", "l2_flush in reset", int'(l2_flush), 0);
    chk("R1", "ken_n in reset", int'(ken_n), 0);
    chk("R1", "wbwt in reset", int'(wbwt), 1);
    @(negedge clk);
    rst_n = 1'b1;
    tick(5);
    chk("R1", "flush_n after reset", int'(flush_n), 1);
    chk("R1", "ken_n after reset", int'(ken_n), 0);
    for (int k = 0; k < 8; k++) begin
      episode(k[2], k[1], k[0]);
    end
    // repeat the sweep to show state returns cleanly between episodes
    for (int k = 7; k >= 0; k--) begin
      episode(k[2], k[1], k[0]);
    end
    chk("R9", "flush pair mismatches", pair_errs, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule